// File: doc/BRIEF.md
# Serial and Parallel Configuration Register Port

This block holds the setup registers of a print-line video path: a mode word, the top and left margin reload values, the line length and line count reload values, and the margin color. Their contents are presented as plain parallel outputs to the counting and output logic next to it. Software can load the registers through either of two ports. The first is a four-wire serial slave with chip select, serial clock, data in and data out. The second is a byte-wide port with a 4-bit address and separate read and write strobes.

A serial transaction starts when chip select falls. It first carries an 8-bit register address and then that register's data, both least significant bit first. The data-in line is sampled on each rising serial clock edge. The same bit is sent back on the data-out line after the next falling edge, so the output repeats the input stream and does not return register contents. The number of bits a transaction must carry depends on the register addressed. The update is applied when chip select rises, and only if exactly that many bits arrived. Margin color data is the 8 color bits followed by 16 zero bits.

All port pins are sampled into a single core clock domain through a synchronizer chain, and edges are detected there. No data stream passes through the block, so no valid/ready handshake exists and nothing can apply back-pressure. Both ports accept a new transfer only at the pace the bus master sets.

Top module: `cfg_regport`

## Requirements
- R1: After reset every register output and every mode output is zero, and `ser_dout_en` is low.
- R2: A serial transaction applies its data at chip select rise when it carried exactly the bit count for its address (address bits included): 0x10 mode word 19, 0x30 top margin 20, 0x50 left margin 20, 0x70 line length 30, 0x90 line count 30, 0xB0 margin color 32. Data bit k is the (9+k)-th bit shifted in.
- R3: A serial transaction with one bit more or fewer than its address requires leaves all registers unchanged.
- R4: A serial transaction to any address outside the six listed in R2 leaves all registers unchanged.
- R5: For address 0xB0 the margin color takes the first 8 data bits. The transaction is rejected, leaving all registers unchanged, if any of the following 16 padding bits is 1.
- R6: After each falling serial clock edge `ser_dout` equals the bit sampled at the preceding rising edge. `ser_dout_en` is high exactly while chip select is low.
- R7: Serial clock edges while chip select is high change no register and produce no output enable.
- R8: Mode outputs decode the 11-bit mode word: bit 0 bi-level, bit 3 little endian, bit 4 bit 7 shifted first, bit 10 saturation. The stream 0x10, 0x19, 0x04 (19 bits) gives mode word 0x419 with all four set.
- R9: A parallel write takes effect on the rising edge of `par_wr_n`. Addresses map as follows: 0x0 mode[7:0], 0x1 mode[10:8], 0x2/0x3 top margin low byte/high nibble, 0x4/0x5 left margin low byte/high nibble, 0x6/0x7/0x8 line length [7:0]/[15:8]/[21:16], 0x9/0xA/0xB line count likewise, 0xC margin color.
- R10: While `par_rd_n` is low, `par_rdata` combinationally shows the addressed slice, zero-extended. Otherwise it shows zero, and addresses 0xD to 0xF read as zero.
- R11: Parallel writes to addresses 0xD to 0xF change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all port pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Serial chip select, active low |
| ser_clk | input | 1 | Serial clock, idles low |
| ser_din | input | 1 | Serial data in, LSB first |
| ser_dout | output | 1 | Echo of the serial input stream |
| ser_dout_en | output | 1 | Drive enable for `ser_dout` |
| par_addr | input | 4 | Parallel register slice address |
| par_wdata | input | 8 | Parallel write data |
| par_rdata | output | 8 | Parallel read data |
| par_wr_n | input | 1 | Parallel write strobe, active low |
| par_rd_n | input | 1 | Parallel read strobe, active low |
| cfg_mode | output | 11 | Mode word |
| mode_bilevel | output | 1 | 1-bit output mode selected |
| mode_little_endian | output | 1 | Byte 0 on the low input byte |
| mode_msb_first | output | 1 | Shift bit 7 first |
| mode_saturate | output | 1 | Replicate serial bit on the byte bus |
| top_margin | output | 12 | Top margin line count reload |
| left_margin | output | 12 | Left margin dot count reload |
| line_len | output | 22 | Line length reload |
| line_count | output | 22 | Line count reload |
| margin_color | output | 8 | Margin color value |

## Verification
The bench sends transactions one bit short and one bit long for every address. A design that commits on a minimum count, or counts the address wrongly, would then overwrite a register. It sends color writes with nonzero padding, which a design that ignores the padding would accept, and unknown addresses, which a design with loose decoding would commit to some register. Every echoed bit is compared after each falling edge, so a one-bit slip or an echo of register data shows up at once. Clock toggles under a high chip select and writes to the unused parallel addresses would show a design that leaks shifting or decode into idle states.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int ADDR_W    = 8;
  localparam int MODE_W    = 11;
  localparam int MARGIN_W  = 12;
  localparam int COUNT_W   = 22;
  localparam int COLOR_W   = 8;
  localparam int PAD_W     = 16;
  localparam int PAYLOAD_W = COLOR_W + PAD_W;
  localparam int FRAME_W   = ADDR_W + PAYLOAD_W;
  localparam int CNT_W     = $clog2(FRAME_W + 2);
  localparam int IDX_W     = $clog2(FRAME_W);
  localparam int PADDR_W   = 4;
  localparam int PDATA_W   = 8;

  localparam logic [ADDR_W-1:0] A_MODE  = 8'h10;
  localparam logic [ADDR_W-1:0] A_TOP   = 8'h30;
  localparam logic [ADDR_W-1:0] A_LEFT  = 8'h50;
  localparam logic [ADDR_W-1:0] A_LLEN  = 8'h70;
  localparam logic [ADDR_W-1:0] A_LCNT  = 8'h90;
  localparam logic [ADDR_W-1:0] A_COLOR = 8'hB0;

  typedef enum logic [PADDR_W-1:0] {
    P_MODE_LO = 4'h0, P_MODE_HI = 4'h1,
    P_TOP_LO  = 4'h2, P_TOP_HI  = 4'h3,
    P_LEFT_LO = 4'h4, P_LEFT_HI = 4'h5,
    P_LLEN_0  = 4'h6, P_LLEN_1  = 4'h7, P_LLEN_2 = 4'h8,
    P_LCNT_0  = 4'h9, P_LCNT_1  = 4'hA, P_LCNT_2 = 4'hB,
    P_COLOR   = 4'hC
  } par_slice_e;

  // Total serial bits required for an address; zero marks an unknown address.
  function automatic logic [CNT_W-1:0] frame_bits(input logic [ADDR_W-1:0] a);
    case (a)
      A_MODE:  return CNT_W'(ADDR_W + MODE_W);
      A_TOP:   return CNT_W'(ADDR_W + MARGIN_W);
      A_LEFT:  return CNT_W'(ADDR_W + MARGIN_W);
      A_LLEN:  return CNT_W'(ADDR_W + COUNT_W);
      A_LCNT:  return CNT_W'(ADDR_W + COUNT_W);
      A_COLOR: return CNT_W'(ADDR_W + COLOR_W + PAD_W);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[CHAIN_W-W-1:0], din};
      end
    end
  endgenerate

  assign dout = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfgport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n_s,
  input  logic                 sclk_s,
  input  logic                 din_s,
  output logic                 dout,
  output logic                 dout_en,
  output logic                 wr,
  output logic [ADDR_W-1:0]    addr,
  output logic [PAYLOAD_W-1:0] data
);
  logic               sclk_q, cs_q, last_bit;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   bits, need;
  logic               rise, fall, cs_up, pad_ok, good;

  assign rise   = sclk_s & ~sclk_q;
  assign fall   = ~sclk_s & sclk_q;
  assign cs_up  = cs_n_s & ~cs_q;
  assign need   = frame_bits(frame[ADDR_W-1:0]);
  assign pad_ok = (frame[ADDR_W-1:0] != A_COLOR) ||
                  (frame[FRAME_W-1:ADDR_W+COLOR_W] == '0);
  assign good   = (need != '0) && (bits == need) && pad_ok;
  assign dout_en = ~cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      last_bit <= 1'b0;
      frame    <= '0;
      bits     <= '0;
      dout     <= 1'b0;
      wr       <= 1'b0;
      addr     <= '0;
      data     <= '0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_n_s;
      wr     <= cs_up & good;
      if (cs_up) begin
        addr <= frame[ADDR_W-1:0];
        data <= frame[FRAME_W-1:ADDR_W];
      end
      if (cs_n_s) begin
        bits  <= '0;
        frame <= '0;
        dout  <= 1'b0;
      end else begin
        if (rise) begin
          if (bits < CNT_W'(FRAME_W)) frame[bits[IDX_W-1:0]] <= din_s;
          if (bits <= CNT_W'(FRAME_W)) bits <= bits + 1'b1;
          last_bit <= din_s;
        end
        if (fall) dout <= last_bit;
      end
    end
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfgport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_wr,
  input  logic [ADDR_W-1:0]    ser_addr,
  input  logic [PAYLOAD_W-1:0] ser_data,
  input  logic                 par_wr,
  input  logic [PADDR_W-1:0]   par_addr,
  input  logic [PDATA_W-1:0]   par_wdata,
  output logic [MODE_W-1:0]    mode,
  output logic [MARGIN_W-1:0]  top,
  output logic [MARGIN_W-1:0]  left,
  output logic [COUNT_W-1:0]   llen,
  output logic [COUNT_W-1:0]   lcnt,
  output logic [COLOR_W-1:0]   color
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;
      top   <= '0;
      left  <= '0;
      llen  <= '0;
      lcnt  <= '0;
      color <= '0;
    end else if (ser_wr) begin
      case (ser_addr)
        A_MODE:  mode  <= ser_data[MODE_W-1:0];
        A_TOP:   top   <= ser_data[MARGIN_W-1:0];
        A_LEFT:  left  <= ser_data[MARGIN_W-1:0];
        A_LLEN:  llen  <= ser_data[COUNT_W-1:0];
        A_LCNT:  lcnt  <= ser_data[COUNT_W-1:0];
        A_COLOR: color <= ser_data[COLOR_W-1:0];
        default: ;
      endcase
    end else if (par_wr) begin
      case (par_slice_e'(par_addr))
        P_MODE_LO: mode[7:0]          <= par_wdata;
        P_MODE_HI: mode[MODE_W-1:8]   <= par_wdata[MODE_W-9:0];
        P_TOP_LO:  top[7:0]           <= par_wdata;
        P_TOP_HI:  top[MARGIN_W-1:8]  <= par_wdata[MARGIN_W-9:0];
        P_LEFT_LO: left[7:0]          <= par_wdata;
        P_LEFT_HI: left[MARGIN_W-1:8] <= par_wdata[MARGIN_W-9:0];
        P_LLEN_0:  llen[7:0]          <= par_wdata;
        P_LLEN_1:  llen[15:8]         <= par_wdata;
        P_LLEN_2:  llen[COUNT_W-1:16] <= par_wdata[COUNT_W-17:0];
        P_LCNT_0:  lcnt[7:0]          <= par_wdata;
        P_LCNT_1:  lcnt[15:8]         <= par_wdata;
        P_LCNT_2:  lcnt[COUNT_W-1:16] <= par_wdata[COUNT_W-17:0];
        P_COLOR:   color              <= par_wdata[COLOR_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_readmux.sv
module cfg_readmux
  import cfgport_pkg::*;
(
  input  logic                rd_n,
  input  logic [PADDR_W-1:0]  addr,
  input  logic [MODE_W-1:0]   mode,
  input  logic [MARGIN_W-1:0] top,
  input  logic [MARGIN_W-1:0] left,
  input  logic [COUNT_W-1:0]  llen,
  input  logic [COUNT_W-1:0]  lcnt,
  input  logic [COLOR_W-1:0]  color,
  output logic [PDATA_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (!rd_n) begin
      case (par_slice_e'(addr))
        P_MODE_LO: rdata = mode[7:0];
        P_MODE_HI: rdata = PDATA_W'(mode[MODE_W-1:8]);
        P_TOP_LO:  rdata = top[7:0];
        P_TOP_HI:  rdata = PDATA_W'(top[MARGIN_W-1:8]);
        P_LEFT_LO: rdata = left[7:0];
        P_LEFT_HI: rdata = PDATA_W'(left[MARGIN_W-1:8]);
        P_LLEN_0:  rdata = llen[7:0];
        P_LLEN_1:  rdata = llen[15:8];
        P_LLEN_2:  rdata = PDATA_W'(llen[COUNT_W-1:16]);
        P_LCNT_0:  rdata = lcnt[7:0];
        P_LCNT_1:  rdata = lcnt[15:8];
        P_LCNT_2:  rdata = PDATA_W'(lcnt[COUNT_W-1:16]);
        P_COLOR:   rdata = PDATA_W'(color);
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_regport.sv
module cfg_regport
  import cfgport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_cs_n,
  input  logic                ser_clk,
  input  logic                ser_din,
  output logic                ser_dout,
  output logic                ser_dout_en,
  input  logic [PADDR_W-1:0]  par_addr,
  input  logic [PDATA_W-1:0]  par_wdata,
  output logic [PDATA_W-1:0]  par_rdata,
  input  logic                par_wr_n,
  input  logic                par_rd_n,
  output logic [MODE_W-1:0]   cfg_mode,
  output logic                mode_bilevel,
  output logic                mode_little_endian,
  output logic                mode_msb_first,
  output logic                mode_saturate,
  output logic [MARGIN_W-1:0] top_margin,
  output logic [MARGIN_W-1:0] left_margin,
  output logic [COUNT_W-1:0]  line_len,
  output logic [COUNT_W-1:0]  line_count,
  output logic [COLOR_W-1:0]  margin_color
);
  localparam int PIN_W = 4;
  localparam logic [PIN_W-1:0] PIN_IDLE = 4'b1001; // {wr_n, din, clk, cs_n}

  logic [PIN_W-1:0]     pins_s;
  logic                 wr_q, par_wr, ser_wr;
  logic [ADDR_W-1:0]    ser_addr;
  logic [PAYLOAD_W-1:0] ser_data;

  cfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({par_wr_n, ser_din, ser_clk, ser_cs_n}),
    .dout(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= pins_s[3];
  end
  assign par_wr = pins_s[3] & ~wr_q;

  cfg_serial_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(pins_s[0]), .sclk_s(pins_s[1]), .din_s(pins_s[2]),
    .dout(ser_dout), .dout_en(ser_dout_en),
    .wr(ser_wr), .addr(ser_addr), .data(ser_data)
  );

  cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .ser_wr(ser_wr), .ser_addr(ser_addr), .ser_data(ser_data),
    .par_wr(par_wr), .par_addr(par_addr), .par_wdata(par_wdata),
    .mode(cfg_mode), .top(top_margin), .left(left_margin),
    .llen(line_len), .lcnt(line_count), .color(margin_color)
  );

  cfg_readmux u_rmux (
    .rd_n(par_rd_n), .addr(par_addr),
    .mode(cfg_mode), .top(top_margin), .left(left_margin),
    .llen(line_len), .lcnt(line_count), .color(margin_color),
    .rdata(par_rdata)
  );

  assign mode_bilevel       = cfg_mode[0];
  assign mode_little_endian = cfg_mode[3];
  assign mode_msb_first     = cfg_mode[4];
  assign mode_saturate      = cfg_mode[10];
endmodule

// File: rtl/cfg_regport_checker.sv
module cfg_regport_checker
  import cfgport_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ser_wr,
  input logic                 par_wr,
  input logic [ADDR_W-1:0]    ser_addr,
  input logic [PAYLOAD_W-1:0] ser_data,
  input logic [MODE_W-1:0]    cfg_mode,
  input logic [MARGIN_W-1:0]  top_margin,
  input logic [MARGIN_W-1:0]  left_margin,
  input logic [COUNT_W-1:0]   line_len,
  input logic [COUNT_W-1:0]   line_count,
  input logic [COLOR_W-1:0]   margin_color
);
  assert_regs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_wr || par_wr) |=> $stable({cfg_mode, top_margin, left_margin,
                                     line_len, line_count, margin_color}));

  assert_commit_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_wr |=> !ser_wr);

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_wr && ser_addr == A_MODE) |=> cfg_mode == $past(ser_data[MODE_W-1:0]));

  assert_color_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_wr && ser_addr == A_COLOR) |=> margin_color == $past(ser_data[COLOR_W-1:0]));

  assert_one_writer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_wr && par_wr));
endmodule

bind cfg_regport cfg_regport_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ser_wr(ser_wr), .par_wr(par_wr),
  .ser_addr(ser_addr), .ser_data(ser_data),
  .cfg_mode(cfg_mode), .top_margin(top_margin), .left_margin(left_margin),
  .line_len(line_len), .line_count(line_count), .margin_color(margin_color)
);

// File: tb/cfg_regport_test.sv
module cfg_regport_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0;
  logic ser_cs_n = 1, ser_clk = 0, ser_din = 0;
  logic ser_dout, ser_dout_en;
  logic [3:0] par_addr = 0;
  logic [7:0] par_wdata = 0, par_rdata;
  logic par_wr_n = 1, par_rd_n = 1;
  logic [10:0] cfg_mode;
  logic mode_bilevel, mode_little_endian, mode_msb_first, mode_saturate;
  logic [11:0] top_margin, left_margin;
  logic [21:0] line_len, line_count;
  logic [7:0] margin_color;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [10:0] m_mode;
  logic [11:0] m_top, m_left;
  logic [21:0] m_llen, m_lcnt;
  logic [7:0]  m_color;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_regport uut (.*);

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int blen(input logic [7:0] a);
    case (a)
      8'h10: return 19;
      8'h30, 8'h50: return 20;
      8'h70, 8'h90: return 30;
      8'hB0: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return m_mode[7:0];
      4'h1: return {5'd0, m_mode[10:8]};
      4'h2: return m_top[7:0];
      4'h3: return {4'd0, m_top[11:8]};
      4'h4: return m_left[7:0];
      4'h5: return {4'd0, m_left[11:8]};
      4'h6: return m_llen[7:0];
      4'h7: return m_llen[15:8];
      4'h8: return {2'd0, m_llen[21:16]};
      4'h9: return m_lcnt[7:0];
      4'hA: return m_lcnt[15:8];
      4'hB: return {2'd0, m_lcnt[21:16]};
      4'hC: return m_color;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_all(input string tag);
    check({tag, " mode"},  32'(cfg_mode), 32'(m_mode));
    check({tag, " top"},   32'(top_margin), 32'(m_top));
    check({tag, " left"},  32'(left_margin), 32'(m_left));
    check({tag, " llen"},  32'(line_len), 32'(m_llen));
    check({tag, " lcnt"},  32'(line_count), 32'(m_lcnt));
    check({tag, " color"}, 32'(margin_color), 32'(m_color));
    check("R8 mode bits", {28'd0, mode_saturate, mode_msb_first, mode_little_endian, mode_bilevel},
          {28'd0, m_mode[10], m_mode[4], m_mode[3], m_mode[0]});
  endtask

  task automatic ser_xfer(input string tag, input logic [7:0] a, input logic [23:0] d, input int n);
    logic [31:0] fr;
    logic b;
    int need;
    fr = {d, a};
    ser_cs_n = 0;
    tick(HALF);
    check("R6 dout_en during select", 32'(ser_dout_en), 32'd1);
    for (int i = 0; i < n; i++) begin
      b = (i < 32) ? fr[i] : 1'b0;
      ser_din = b;
      tick(HALF);
      ser_clk = 1;
      tick(HALF);
      ser_clk = 0;
      tick(HALF);
      check("R6 echo", 32'(ser_dout), 32'(b));
    end
    ser_cs_n = 1;
    tick(8);
    check("R6 dout_en idle", 32'(ser_dout_en), 32'd0);
    need = blen(a);
    if (need != 0 && n == need && (a != 8'hB0 || d[23:8] == 16'd0)) begin
      case (a)
        8'h10: m_mode  = d[10:0];
        8'h30: m_top   = d[11:0];
        8'h50: m_left  = d[11:0];
        8'h70: m_llen  = d[21:0];
        8'h90: m_lcnt  = d[21:0];
        default: m_color = d[7:0];
      endcase
    end
    check_all(tag);
  endtask

  task automatic par_write(input logic [3:0] a, input logic [7:0] d);
    par_addr = a;
    par_wdata = d;
    par_wr_n = 0;
    tick(4);
    par_wr_n = 1;
    tick(6);
    case (a)
      4'h0: m_mode[7:0]   = d;
      4'h1: m_mode[10:8]  = d[2:0];
      4'h2: m_top[7:0]    = d;
      4'h3: m_top[11:8]   = d[3:0];
      4'h4: m_left[7:0]   = d;
      4'h5: m_left[11:8]  = d[3:0];
      4'h6: m_llen[7:0]   = d;
      4'h7: m_llen[15:8]  = d;
      4'h8: m_llen[21:16] = d[5:0];
      4'h9: m_lcnt[7:0]   = d;
      4'hA: m_lcnt[15:8]  = d;
      4'hB: m_lcnt[21:16] = d[5:0];
      4'hC: m_color       = d;
      default: ;
    endcase
  endtask

  task automatic par_read_all(input string tag);
    for (int a = 0; a < 16; a++) begin
      par_addr = 4'(a);
      par_rd_n = 0;
      #1;
      check({tag, " R10 read"}, 32'(par_rdata), 32'(exp_read(4'(a))));
      par_rd_n = 1;
      #1;
      check("R10 idle read zero", 32'(par_rdata), 32'd0);
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] addrs [7];
    void'($urandom(32'd4242));
    addrs = '{8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'h20};
    m_mode = 0; m_top = 0; m_left = 0; m_llen = 0; m_lcnt = 0; m_color = 0;

    tick(5);
    rst_n = 1;
    tick(3);
    check_all("R1 reset");
    check("R1 dout_en reset", 32'(ser_dout_en), 32'd0);

    // R8: example stream, then R2 each address with exact length
    ser_xfer("R8 example", 8'h10, 24'h000419, 19);
    check("R8 mode word", 32'(cfg_mode), 32'h419);
    ser_xfer("R2 top",   8'h30, 24'h000ABC, 20);
    ser_xfer("R2 left",  8'h50, 24'h000123, 20);
    ser_xfer("R2 llen",  8'h70, 24'h2D5A3C, 30);
    ser_xfer("R2 lcnt",  8'h90, 24'h13579B, 30);
    ser_xfer("R2 color", 8'hB0, 24'h0000C7, 32);
    // R3 short and long
    ser_xfer("R3 short", 8'h70, 24'h001111, 29);
    ser_xfer("R3 long",  8'h30, 24'h000777, 21);
    ser_xfer("R3 short color", 8'hB0, 24'h000011, 31);
    ser_xfer("R3 abort", 8'h10, 24'h0007FF, 5);
    // R4 unknown address
    ser_xfer("R4 unknown", 8'h20, 24'h0007FF, 19);
    ser_xfer("R4 unknown long", 8'hB1, 24'h0000FF, 32);
    // R5 padding nonzero
    ser_xfer("R5 padding", 8'hB0, 24'h010055, 32);
    ser_xfer("R5 pad top", 8'hB0, 24'h800033, 32);

    // R7 serial clock toggles with select high
    ser_din = 1;
    for (int i = 0; i < 12; i++) begin
      ser_clk = 1; tick(HALF);
      ser_clk = 0; tick(HALF);
      check("R7 dout_en stays low", 32'(ser_dout_en), 32'd0);
    end
    ser_din = 0;
    check_all("R7 idle clocks");

    // random serial mix
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a;
      logic [23:0] d;
      int n;
      a = addrs[$urandom % 7];
      d = 24'($urandom);
      if (a == 8'hB0 && ($urandom % 4) != 0) d[23:8] = 0;
      n = (blen(a) == 0) ? 19 : blen(a) + int'($urandom % 3) - 1;
      ser_xfer("R2 R3 random", a, d, n);
    end

    par_read_all("R10 after serial");

    // R9 / R11 parallel writes
    par_write(4'h0, 8'h19);
    par_write(4'h1, 8'hFC);
    check_all("R9 mode bytes");
    par_write(4'hD, 8'hFF);
    par_write(4'hF, 8'hA5);
    check_all("R11 unused write");
    for (int k = 0; k < 30; k++) begin
      par_write(4'($urandom % 16), 8'($urandom));
      check_all("R9 R11 random");
      par_read_all("R10 random");
    end

    // serial after parallel
    ser_xfer("R2 after parallel", 8'h50, 24'h000FED, 20);
    par_read_all("R10 final");

    done = 1;
    finish_run();
  end
endmodule